// File: doc/BRIEF.md
# Timed Key Matrix Scan Sequencer

This block scans a key matrix on its own, with no processor involved. It has a parameterised number of column drive lines (16 by default) and row sense inputs (8 by default). It drives one column at a time for a fixed slot of clock cycles. At a single clock edge, a fixed number of cycles after the column was driven, it captures all row inputs together. The sample instant is counted in clock cycles, so it is identical on every column and every pass. Software timing and interrupts cannot move it.

Samples from each column are held internally until the last column has been read. The whole matrix is then published at once as one snapshot word, together with a one-cycle strobe. Scanning runs while `scan_en` is high. When `scan_en` is withdrawn, the block finishes the slot in progress and then parks with every column released. With a 50 MHz clock, the default parameters give a 0.8 µs sample delay, a 40 µs column slot and a 640 µs pass. The row inputs are taken as clean digital levels.

Top module: `kmx_scan_top`

## Requirements
- R1: `col_drv` is one-hot or all zero in every cycle. Bit c high means column c is driven.
- R2: Each column slot lasts SLOT_CYC cycles: one cycle with every column released, followed by SLOT_CYC-1 cycles with the column driven. Two different columns are never driven in back-to-back cycles.
- R3: All row inputs are captured at the one clock edge that ends the SAMPLE_CYC-th consecutive cycle in which the current column is driven. Row values in any other cycle have no effect on the snapshot.
- R4: While scanning continues, columns are driven in ascending order 0, 1, … N_COLS-1 and then wrap to 0. The released gap between two consecutive columns is exactly one cycle.
- R5: After the last column is sampled, `snap` takes the captured values and `snap_vld` is high for exactly one cycle, in the first cycle in which the new snapshot is visible. Bit c*N_ROWS+r of `snap` holds row r as read while column c was driven.
- R6: `snap` changes only in a cycle where `snap_vld` is high.
- R7: While `scan_en` stays high, consecutive `snap_vld` pulses are exactly N_COLS*SLOT_CYC cycles apart.
- R8: Synchronous reset releases all columns, clears `snap` to zero, holds `snap_vld` low, and makes the next scan begin at column 0.
- R9: While `scan_en` is low and no slot is in progress, no column is driven.
- R10: When `scan_en` falls partway through a pass, the current slot runs to its full length. All columns are then released, no snapshot is published for the partial pass, and the next enable starts again at column 0.
- R11: When `scan_en` falls during the last column's slot, at or after that column's sample edge, the snapshot for that pass is still published.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scanning runs while high |
| row_in | input | N_ROWS | Digital row sense levels |
| col_drv | output | N_COLS | One-hot column drive, high = driven |
| snap | output | N_COLS*N_ROWS | Published key-state snapshot |
| snap_vld | output | 1 | One-cycle strobe on a new snapshot |

## Verification
Two things can fall into the same cycle: the capture of the last column, which also publishes the snapshot, and the withdrawal of `scan_en`, which must not cancel that publication or shorten the slot. The bench drops the enable in exactly the cycle that ends with the last column's sample edge. It then expects one more strobe carrying the full matrix, followed by a clean stop. A second drop in the middle of a pass must give the opposite outcome: no strobe, and a restart from column 0. Sample timing is judged by driving the intended row pattern only in the single cycle before the sample edge and its complement in every other cycle, so a capture one cycle early or late shows up as inverted bits in the snapshot.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    // Per-cycle events decoded from the slot counter
    typedef struct packed {
        logic drive;     // a column may be driven this cycle
        logic sample;    // rows are captured at the edge ending this cycle
        logic slot_end;  // last cycle of the current slot
    } slot_evt_t;

    function automatic int unsigned kmx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/kmx_slot_timer.sv
module kmx_slot_timer
    import kmx_pkg::*;
#(
    parameter int unsigned SLOT_CYC   = 2000,
    parameter int unsigned SAMPLE_CYC = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output slot_evt_t evt
);
    localparam int unsigned CW = kmx_bits(SLOT_CYC);
    localparam logic [CW-1:0] LAST_CNT   = CW'(SLOT_CYC - 1);
    localparam logic [CW-1:0] SAMPLE_CNT = CW'(SAMPLE_CYC);

    logic [CW-1:0] cnt_q;

    // Count 0 is the released gap; the column is driven from count 1 on
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_CNT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        evt.drive    = run && (cnt_q != '0);
        evt.sample   = run && (cnt_q == SAMPLE_CNT);
        evt.slot_end = run && (cnt_q == LAST_CNT);
    end

endmodule

// File: rtl/kmx_col_seq.sv
module kmx_col_seq
    import kmx_pkg::*;
#(
    parameter int unsigned N_COLS = 16,
    localparam int unsigned IW = kmx_bits(N_COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_en,
    input  slot_evt_t     evt,
    output logic          run,
    output logic [IW-1:0] col_idx,
    output logic          last_col
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N_COLS - 1);

    scan_state_e   state_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SCAN_IDLE: begin
                    if (scan_en) begin
                        state_q <= SCAN_RUN;
                        idx_q   <= '0;
                    end
                end
                SCAN_RUN: begin
                    if (evt.slot_end) begin
                        if (scan_en) begin
                            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                        end else begin
                            // Park; a partial pass is dropped
                            state_q <= SCAN_IDLE;
                            idx_q   <= '0;
                        end
                    end
                end
                default: begin
                    state_q <= SCAN_IDLE;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    assign run      = (state_q == SCAN_RUN);
    assign col_idx  = idx_q;
    assign last_col = (idx_q == LAST_IDX);

endmodule

// File: rtl/kmx_col_drive.sv
module kmx_col_drive
    import kmx_pkg::*;
#(
    parameter int unsigned N_COLS = 16,
    localparam int unsigned IW = kmx_bits(N_COLS)
) (
    input  logic              drive,
    input  logic [IW-1:0]     col_idx,
    output logic [N_COLS-1:0] col_drv
);
    for (genvar g = 0; g < N_COLS; g++) begin : g_dec
        assign col_drv[g] = drive && (col_idx == IW'(g));
    end

endmodule

// File: rtl/kmx_shadow.sv
module kmx_shadow
    import kmx_pkg::*;
#(
    parameter int unsigned N_COLS = 16,
    parameter int unsigned N_ROWS = 8,
    localparam int unsigned IW = kmx_bits(N_COLS),
    localparam int unsigned SW = N_COLS * N_ROWS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              last_col,
    input  logic [IW-1:0]     col_idx,
    input  logic [N_ROWS-1:0] row_in,
    output logic [SW-1:0]     snap,
    output logic              snap_vld
);
    logic [SW-1:0] snap_nxt;

    for (genvar g = 0; g < N_COLS; g++) begin : g_col
        if (g == N_COLS - 1) begin : g_last
            // Final column goes straight into the snapshot
            assign snap_nxt[g*N_ROWS +: N_ROWS] = row_in;
        end else begin : g_held
            logic [N_ROWS-1:0] held_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    held_q <= '0;
                end else if (sample && col_idx == IW'(g)) begin
                    held_q <= row_in;
                end
            end
            assign snap_nxt[g*N_ROWS +: N_ROWS] = held_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap     <= '0;
            snap_vld <= 1'b0;
        end else begin
            snap_vld <= sample && last_col;
            if (sample && last_col) begin
                snap <= snap_nxt;
            end
        end
    end

endmodule

// File: rtl/kmx_scan_top.sv
module kmx_scan_top
    import kmx_pkg::*;
#(
    parameter int unsigned N_COLS     = 16,
    parameter int unsigned N_ROWS     = 8,
    parameter int unsigned SLOT_CYC   = 2000,
    parameter int unsigned SAMPLE_CYC = 40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scan_en,
    input  logic [N_ROWS-1:0]          row_in,
    output logic [N_COLS-1:0]          col_drv,
    output logic [N_COLS*N_ROWS-1:0]   snap,
    output logic                       snap_vld
);
    localparam int unsigned IW = kmx_bits(N_COLS);

    slot_evt_t     evt;
    logic          run;
    logic          last_col;
    logic [IW-1:0] col_idx;

    kmx_slot_timer #(
        .SLOT_CYC   (SLOT_CYC),
        .SAMPLE_CYC (SAMPLE_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .run (run),
        .evt (evt)
    );

    kmx_col_seq #(
        .N_COLS (N_COLS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .evt      (evt),
        .run      (run),
        .col_idx  (col_idx),
        .last_col (last_col)
    );

    kmx_col_drive #(
        .N_COLS (N_COLS)
    ) u_drive (
        .drive   (evt.drive),
        .col_idx (col_idx),
        .col_drv (col_drv)
    );

    kmx_shadow #(
        .N_COLS (N_COLS),
        .N_ROWS (N_ROWS)
    ) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .sample   (evt.sample),
        .last_col (last_col),
        .col_idx  (col_idx),
        .row_in   (row_in),
        .snap     (snap),
        .snap_vld (snap_vld)
    );

endmodule

// File: rtl/kmx_scan_chk.sv
module kmx_scan_chk #(
    parameter int unsigned N_COLS   = 16,
    parameter int unsigned N_ROWS   = 8,
    parameter int unsigned SLOT_CYC = 2000
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_COLS-1:0]        col_drv,
    input logic [N_COLS*N_ROWS-1:0] snap,
    input logic                     snap_vld
);
    localparam int unsigned RW = $clog2(SLOT_CYC + 1);
    localparam logic [N_COLS-1:0] LAST_HOT = N_COLS'(1) << (N_COLS - 1);

    // Length of the current run of driven cycles
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (col_drv != '0) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_drv)); // R1

    AST_COL_GAP: assert property (@(posedge clk) disable iff (rst)
        (col_drv != '0 && $past(col_drv) != '0) |-> (col_drv == $past(col_drv))); // R2

    AST_SLOT_LEN: assert property (@(posedge clk) disable iff (rst)
        (col_drv == '0 && $past(col_drv) != '0 && !$past(rst)) |-> (run_q == RW'(SLOT_CYC - 1))); // R2

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        snap_vld |=> !snap_vld); // R5

    AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        snap_vld |-> ($past(col_drv) == LAST_HOT)); // R5

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (snap != $past(snap)) |-> snap_vld); // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (col_drv == '0 && snap == '0 && !snap_vld)); // R8

endmodule

bind kmx_scan_top kmx_scan_chk #(
    .N_COLS   (N_COLS),
    .N_ROWS   (N_ROWS),
    .SLOT_CYC (SLOT_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .col_drv  (col_drv),
    .snap     (snap),
    .snap_vld (snap_vld)
);

// File: tb/kmx_scan_top_test.sv
module kmx_scan_top_test;

    localparam int NC = 16;
    localparam int NR = 8;
    localparam int SL = 12;
    localparam int CD = 5;
    localparam int SW = NC * NR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en = 1'b0;
    logic [NR-1:0] row_in = '0;
    logic [NC-1:0] col_drv;
    logic [SW-1:0] snap;
    logic          snap_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    kmx_scan_top #(
        .N_COLS     (NC),
        .N_ROWS     (NR),
        .SLOT_CYC   (SL),
        .SAMPLE_CYC (CD)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .row_in   (row_in),
        .col_drv  (col_drv),
        .snap     (snap),
        .snap_vld (snap_vld)
    );

    function automatic logic [SW-1:0] key_pattern(input int p);
        case (p)
            0: return '1;
            1: return '0;
            2: return {(SW/2){2'b10}};
            default: return {$urandom, $urandom, $urandom, $urandom};
        endcase
    endfunction

    function automatic int hot_index(input logic [NC-1:0] v);
        for (int i = 0; i < NC; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: matrix model, ordering, slot lengths, snapshots
    logic [NC-1:0] prev_col;
    logic [SW-1:0] keymap;
    logic [SW-1:0] prev_snap;
    int run_len, zero_len, last_idx, vcount, last_valid, cyc;
    bit en_low_seen;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_col = '0; run_len = 0; zero_len = 0; last_idx = -1;
            vcount = 0; last_valid = -1; en_low_seen = 1'b0;
            keymap = key_pattern(0); prev_snap = snap; row_in = '0;
        end else begin
            if (!scan_en) en_low_seen = 1'b1;
            chk($onehot0(col_drv), "R1 one-hot", SW'(col_drv), '0);
            if (col_drv != '0) begin
                if (prev_col == '0) begin
                    int exp_idx;
                    exp_idx = (zero_len == 1 && last_idx >= 0) ? (last_idx + 1) % NC : 0;
                    chk(hot_index(col_drv) == exp_idx, "R4 column order",
                        SW'(hot_index(col_drv)), SW'(exp_idx));
                    last_idx = hot_index(col_drv);
                    run_len = 1;
                end else begin
                    if (col_drv != prev_col)
                        chk(1'b0, "R2 no gap between columns", SW'(col_drv), SW'(prev_col));
                    run_len++;
                end
                zero_len = 0;
                // Correct rows only in the cycle ending at the sample edge (R3)
                if (run_len == CD) row_in = keymap[last_idx*NR +: NR];
                else               row_in = ~keymap[last_idx*NR +: NR];
            end else begin
                if (prev_col != '0)
                    chk(run_len == SL - 1, "R2 slot length", SW'(run_len), SW'(SL - 1));
                zero_len++;
                run_len = 0;
                row_in = NR'($urandom);
            end
            prev_col = col_drv;

            if (snap_vld) begin
                chk(snap == keymap, "R3/R5 snapshot content", snap, keymap);
                if (last_valid >= 0 && !en_low_seen)
                    chk(cyc - last_valid == NC * SL, "R7 pass period",
                        SW'(cyc - last_valid), SW'(NC * SL));
                last_valid = cyc;
                en_low_seen = 1'b0;
                vcount++;
                keymap = key_pattern(vcount);
            end else if (snap != prev_snap) begin
                chk(1'b0, "R6 snapshot hold", snap, prev_snap);
            end
            prev_snap = snap;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed_v;
        int rec;
        bit all_off;
        seed_v = $urandom(32'd20240611);
        cycles(4);
        chk(col_drv == '0 && snap == '0 && !snap_vld, "R8 reset state",
            {snap[SW-1:NC+1], snap_vld, col_drv}, '0);
        rst = 1'b0;

        // R9: idle while disabled
        all_off = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (col_drv != '0) all_off = 1'b0;
        end
        chk(all_off, "R9 idle with enable low", SW'(all_off), SW'(1));

        scan_en = 1'b1;
        while (col_drv == '0) @(negedge clk);
        chk(col_drv == NC'(1), "R8 first column after reset", SW'(col_drv), SW'(1));
        while (vcount < 5) @(negedge clk);

        // R10: drop enable mid-pass
        while (col_drv != NC'(1) << 6) @(negedge clk);
        cycles(3);
        scan_en = 1'b0;
        rec = vcount;
        while (col_drv != '0) @(negedge clk);
        all_off = 1'b1;
        for (int i = 0; i < 3 * SL; i++) begin
            @(negedge clk);
            if (col_drv != '0) all_off = 1'b0;
        end
        chk(all_off, "R10 columns released after stop", SW'(all_off), SW'(1));
        chk(vcount == rec, "R10 no snapshot for partial pass", SW'(vcount), SW'(rec));
        scan_en = 1'b1;
        while (col_drv == '0) @(negedge clk);
        chk(col_drv == NC'(1), "R10 restart at column 0", SW'(col_drv), SW'(1));
        rec = vcount;
        while (vcount < rec + 2) @(negedge clk);

        // R11: drop enable in the cycle ending at the last column's sample edge
        while (col_drv != NC'(1) << (NC - 2)) @(negedge clk);
        while (col_drv != NC'(1) << (NC - 1)) @(negedge clk);
        rec = vcount;
        cycles(CD - 1);
        scan_en = 1'b0;
        cycles(2 * SL);
        chk(vcount == rec + 1, "R11 snapshot kept on late stop", SW'(vcount), SW'(rec + 1));
        chk(col_drv == '0, "R11 stopped after last slot", SW'(col_drv), '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule